// File: doc/BRIEF.md
# Single-Precision to Brain-Float Narrowing Converter

The block turns a 32-bit IEEE-754 single-precision word into a 16-bit brain-float (bfloat16) word. It sorts each input into one of four classes and treats each class with its own rule. Zero and subnormal inputs become a signed zero. Infinities pass through unchanged. NaNs are either kept as a quiet NaN that carries the input's sign and upper payload, or replaced by one fixed quiet NaN. Finite normal values are rounded to nearest, with ties going to even.

The result is registered, so there is one cycle of latency. A valid strobe travels with the data. A mode input picks the NaN policy. The mode is sampled in the same cycle as the word it applies to, so it can change from one word to the next. The block fits in a datapath that narrows activations or weights before storing them.

Top module: `bf16_narrow`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `out_vld` to 0 and `out_half` to 0x0000.
- R2: `out_vld` at each clock edge takes the value `in_vld` had at that edge, which gives one cycle of latency.
- R3: An input with exponent field (bits 30:23) equal to zero yields bit 15 equal to input bit 31 and bits 14:0 equal to zero. This covers zeros and subnormals.
- R4: An input with exponent all ones and fraction (bits 22:0) zero yields input bits 31:16 unchanged.
- R5: An input is a NaN when its exponent is all ones and any of its 23 fraction bits is set, including fraction bits 15:0, which truncation drops.
- R6: With `nan_keep` = 1, a NaN yields input bits 31:16 with output bit 6 forced to 1. This keeps the sign and the top six fraction bits and always gives a quiet NaN.
- R7: With `nan_keep` = 0, every NaN yields 0x7FC0, whatever its sign or payload.
- R8: Any other input yields bits 31:16 of the 32-bit sum of the input, 0x00007FFF and input bit 16. This is round to nearest, ties to even.
- R9: A finite input whose rounding carries into the exponent yields an infinity of the same sign, for example 0x7F7FFFFF → 0x7F80 and 0xFF7FFFFF → 0xFF80.
- R10: `nan_keep` applies only to the word presented in the same cycle, so alternating the mode on consecutive NaNs alternates the policy.
- R11: In a cycle where `in_vld` is 0, `out_half` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input word valid |
| in_word | input | 32 | Single-precision operand |
| nan_keep | input | 1 | 1: keep NaN payload; 0: canonical NaN |
| out_vld | output | 1 | Result valid |
| out_half | output | 16 | Brain-float result |

## Verification
Every result, `out_vld` included, is due exactly one clock edge after the cycle in which its word and mode were presented. The bench drives inputs on the falling edge and, on the next falling edge, compares the outputs with a reference value it computed from the word it presented a cycle earlier. When no word is presented, the held value is compared instead. The bound assertions express the same one-edge relation with `|=>` and `$past` of the inputs.

// File: rtl/bf16_narrow.sv
module bf16_narrow #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 16,
  parameter int EXP_W = 8,
  parameter logic [OUT_W-1:0] CANON_NAN = 16'h7FC0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [IN_W-1:0]  in_word,
  input  logic             nan_keep,
  output logic             out_vld,
  output logic [OUT_W-1:0] out_half
);
  localparam int FRAC_W    = IN_W - 1 - EXP_W;
  localparam int DROP_W    = IN_W - OUT_W;
  localparam int QUIET_BIT = OUT_W - 2 - EXP_W;
  localparam logic [OUT_W-1:0] QUIET_MASK = OUT_W'(1) << QUIET_BIT;
  localparam logic [IN_W-1:0]  RND_BIAS   = IN_W'((64'd1 << (DROP_W - 1)) - 64'd1);

  logic             sgn;
  logic [EXP_W-1:0] expf;
  logic [FRAC_W-1:0] frac;
  logic             exp_lo, exp_hi, frac_nz;
  logic             cls_zero, cls_inf, cls_nan;
  logic [OUT_W-1:0] hi_part;
  logic [IN_W-1:0]  rnd_sum;
  logic [OUT_W-1:0] nan_res;
  logic [OUT_W-1:0] result;

  assign sgn     = in_word[IN_W-1];
  assign expf    = in_word[IN_W-2 -: EXP_W];
  assign frac    = in_word[FRAC_W-1:0];
  assign hi_part = in_word[IN_W-1 -: OUT_W];

  assign exp_lo  = ~|expf;
  assign exp_hi  = &expf;
  assign frac_nz = |frac;

  assign cls_zero = exp_lo;
  assign cls_inf  = exp_hi & ~frac_nz;
  assign cls_nan  = exp_hi & frac_nz;

  assign rnd_sum = in_word + RND_BIAS + {{(IN_W-1){1'b0}}, in_word[DROP_W]};
  assign nan_res = nan_keep ? (hi_part | QUIET_MASK) : CANON_NAN;

  always_comb begin
    if (cls_zero)     result = {sgn, {(OUT_W-1){1'b0}}};
    else if (cls_inf) result = hi_part;
    else if (cls_nan) result = nan_res;
    else              result = rnd_sum[IN_W-1 -: OUT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_half <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_half <= result;
    end
  end
endmodule

module bf16_narrow_chk #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 16,
  parameter int EXP_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_vld,
  input logic [IN_W-1:0]  in_word,
  input logic             nan_keep,
  input logic             out_vld,
  input logic [OUT_W-1:0] out_half
);
  localparam int FRAC_W = IN_W - 1 - EXP_W;
  localparam int QBIT   = OUT_W - 2 - EXP_W;

  logic [EXP_W-1:0] e;
  logic [OUT_W-1:0] hi;
  logic             fz, ez, eo;
  assign e  = in_word[IN_W-2 -: EXP_W];
  assign hi = in_word[IN_W-1 -: OUT_W];
  assign fz = ~|in_word[FRAC_W-1:0];
  assign ez = ~|e;
  assign eo = &e;

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_vld == $past(in_vld)); // R2

  AST_ZERO_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (in_vld && ez) |=> out_half == {$past(in_word[IN_W-1]), {(OUT_W-1){1'b0}}}); // R3

  AST_INF_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_vld && eo && fz) |=> out_half == $past(hi)); // R4

  AST_NAN_KEEP: assert property (@(posedge clk) disable iff (rst)
    (in_vld && eo && !fz && nan_keep) |=> (out_half[QBIT] && out_half == ($past(hi) | (OUT_W'(1) << QBIT)))); // R6

  AST_NAN_CANON: assert property (@(posedge clk) disable iff (rst)
    (in_vld && eo && !fz && !nan_keep) |=> out_half == 16'h7FC0); // R7

  AST_NORM_NEAR: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !ez && !eo) |=> (out_half == $past(hi) || out_half == $past(hi) + OUT_W'(1))); // R8

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!in_vld && !$past(rst)) |=> $stable(out_half)); // R11
endmodule

bind bf16_narrow bf16_narrow_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .in_word(in_word), .nan_keep(nan_keep),
  .out_vld(out_vld), .out_half(out_half)
);

// File: tb/sim_bf16_narrow.sv
`timescale 1ns/1ps
module sim_bf16_narrow;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [31:0] in_word = '0;
  logic        nan_keep = 1'b0;
  logic        out_vld;
  logic [15:0] out_half;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  bf16_narrow u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_word(in_word),
    .nan_keep(nan_keep), .out_vld(out_vld), .out_half(out_half)
  );

  function automatic logic [15:0] model(input logic [31:0] x, input logic keep);
    int ex;
    logic [15:0] top, bot;
    ex  = int'(x[30:23]);
    top = x[31:16];
    bot = x[15:0];
    if (ex == 0) return {x[31], 15'd0};
    if (ex == 255) begin
      if (x[22:0] == 0) return top;
      if (keep) return top | 16'h0040;
      return 16'h7FC0;
    end
    if (bot > 16'h8000 || (bot == 16'h8000 && top[0])) return top + 16'd1;
    return top;
  endfunction

  function automatic string tag_of(input logic [31:0] x, input logic keep);
    if (x[30:23] == 0) return "R3";
    if (x[30:23] == 8'hFF) begin
      if (x[22:0] == 0) return "R4";
      if (x[22:16] == 0) return "R5";
      return keep ? "R6" : "R7";
    end
    if (x[30:16] == 15'h7F7F && x[15]) return "R9";
    return "R8";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic        exp_vld = 1'b0;
  logic [15:0] exp_half = 16'h0;
  string       exp_tag = "R1";

  task automatic step(input logic v, input logic [31:0] w, input logic k);
    @(negedge clk);
    check("R2", 32'(out_vld), 32'(exp_vld));
    check(exp_tag, 32'(out_half), 32'(exp_half));
    in_vld = v; in_word = w; nan_keep = k;
    exp_vld = v;
    if (v) begin
      exp_half = model(w, k);
      exp_tag  = tag_of(w, k);
    end else begin
      exp_tag = "R11";
    end
  endtask

  logic [31:0] dir [15] = '{
    32'h00000000, 32'h80000000, 32'h00000001, 32'h807FFFFF,
    32'h7F800000, 32'hFF800000, 32'h7F800001, 32'hFFC12345,
    32'h7F812345, 32'h3F808000, 32'h3F818000, 32'h3F808001,
    32'h7F7FFFFF, 32'hFF7FFFFF, 32'h3F807FFF
  };

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 32'(out_vld), 32'd0);
    check("R1", 32'(out_half), 32'd0);
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < 15; i++) step(1'b1, dir[i], 1'b1);
    for (int i = 0; i < 15; i++) step(1'b1, dir[i], 1'b0);
    // R10: mode flips on back-to-back NaNs
    for (int i = 0; i < 8; i++) step(1'b1, 32'hFFA0F00D ^ (32'(i) << 20), i[0]);
    // R11: bubbles hold the last result
    step(1'b1, 32'h40490FDB, 1'b0);
    step(1'b0, 32'h7FC00000, 1'b1);
    step(1'b0, 32'h00000000, 1'b0);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      w = $urandom;
      if (i % 7 == 0) w[30:23] = 8'hFF;
      if (i % 11 == 0) w[30:23] = 8'h00;
      if (i % 13 == 0) w[15:0] = 16'h8000;
      step((i % 5) != 0, w, w[3]);
    end
    step(1'b0, 32'h0, 1'b0);
    step(1'b0, 32'h0, 1'b0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule